// File: doc/BRIEF.md
# Two-Wire Command Slave for an Eight-Channel Converter

This block is the serial front end of an eight-channel data-acquisition converter. It sits on a two-wire bus as a slave only. Its data line is modelled as open drain: the block never drives a high level, it only asserts a pull-low enable. The clock and data lines are brought into a fast system clock through a synchroniser, and the block finds START, STOP and clock edges in that domain. The address has a fixed four-bit prefix, and three strap inputs supply the low bits.

A write transaction carries one command byte. The byte's leading bit must be 1. On acceptance the block decodes the byte into a channel, a range flag, a polarity flag and a power mode. These are held as configuration for the conversion sequencer. A STOP that ends an accepted write sends a one-cycle start pulse to that sequencer. A read transaction returns the most recently latched conversion result, left-justified in two bytes. Whether the master acknowledges each byte has no effect on what is sent.

Top module: `adc_cmd_i2c_slave`

## Requirements
- R1: After reset the data line is released (`sda_oe`=0), all configuration outputs are zero (`cfg_chan_onehot`=8'h01), `conv_start` is low and the held result is zero.
- R2: After a START, the block compares the first eight bits sampled on SCL rising edges as address[6:0] then R/W. If address = {4'b0101, addr_strap}, it pulls SDA low through the ninth clock high phase.
- R3: If the address does not match, the block never pulls SDA low, and later bytes up to the next START or STOP have no effect on the configuration.
- R4: A write command byte with bit7=1 is acknowledged on its ninth clock. The byte then sets `cfg_chan`=bits[6:4], `cfg_chan_onehot` with only bit `cfg_chan` set, `cfg_range`=bit3 and `cfg_bipolar`=bit2. It sets `cfg_pwr`=2'b00 when bit1=0 and {1'b1,bit0} when bit1=1, and pulses `cfg_strobe`.
- R5: A command byte with bit7=0 is not acknowledged and leaves every configuration output unchanged.
- R6: A read returns {D11..D4} then {D3..D0,4'b0000}, MSB first. SDA changes only while SCL is low, and both bytes come from one snapshot taken at the address acknowledge.
- R7: During a read the master's ACK or NACK after the first byte does not change the second byte. After the second byte SDA stays released, so any further byte reads 8'hFF.
- R8: `conv_start` pulses for one cycle on a STOP only when a command was accepted since the previous STOP. It does not pulse after reads, rejected addresses or rejected commands.
- R9: A repeated START in any state restarts address reception.
- R10: `result_load` high latches `result_i` into the held result. Before any load the read bytes are 8'h00 and 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired) |
| sda_oe | output | 1 | 1 pulls the data line low |
| addr_strap | input | 3 | Low three address bits |
| result_i | input | RES_W | Conversion result from the converter |
| result_load | input | 1 | Latch `result_i` into the held result |
| cfg_chan | output | 3 | Selected channel |
| cfg_chan_onehot | output | 8 | One-hot form of the selected channel |
| cfg_range | output | 1 | Full-scale range select |
| cfg_bipolar | output | 1 | Bipolar conversion select |
| cfg_pwr | output | 2 | Power mode: 00 on, 10 standby, 11 full down |
| cfg_strobe | output | 1 | One-cycle pulse when configuration is written |
| conv_start | output | 1 | One-cycle pulse at STOP after an accepted command |

## Verification
The bench builds the block with its default parameters: a 12-bit result, a two-stage synchroniser and the 0101 prefix. It ties the straps to 101 and runs SCL with a period of 40 system clocks. At this ratio every acknowledge and every data bit can be sampled in the middle of the SCL high phase. With a 12-bit result the low byte keeps exactly four padding zeros, so the left-justified layout and the fill after the second byte are both visible at the pins.

// File: rtl/adc_i2c_pkg.sv
package adc_i2c_pkg;

   localparam int CMD_W     = 8;
   localparam int CH_SEL_W  = 3;
   localparam int NUM_CH    = 1 << CH_SEL_W;
   localparam int TX_W      = 16;

   typedef enum logic [2:0] {
      LNK_IDLE,
      LNK_ADDR,
      LNK_ADDR_ACK,
      LNK_CMD,
      LNK_CMD_ACK,
      LNK_RD_BYTE,
      LNK_RD_ACK,
      LNK_IGNORE
   } link_state_t;

   typedef enum logic [1:0] {
      PWR_ON   = 2'b00,
      PWR_STBY = 2'b10,
      PWR_FULL = 2'b11
   } pwr_mode_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic [SYNC_STAGES-1:0] scl_chain;
   logic [SYNC_STAGES-1:0] sda_chain;
   logic                   scl_d;
   logic                   sda_d;

   generate
      for (genvar st = 0; st < SYNC_STAGES; st++) begin : g_stage
         if (st == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  scl_chain[st] <= 1'b1;
                  sda_chain[st] <= 1'b1;
               end else begin
                  scl_chain[st] <= scl_i;
                  sda_chain[st] <= sda_i;
               end
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  scl_chain[st] <= 1'b1;
                  sda_chain[st] <= 1'b1;
               end else begin
                  scl_chain[st] <= scl_chain[st-1];
                  sda_chain[st] <= sda_chain[st-1];
               end
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_chain[SYNC_STAGES-1];
         sda_d <= sda_chain[SYNC_STAGES-1];
      end
   end

   assign scl_s     = scl_chain[SYNC_STAGES-1];
   assign sda_s     = sda_chain[SYNC_STAGES-1];
   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_link_fsm.sv
module i2c_link_fsm
   import adc_i2c_pkg::*;
#(
   parameter logic [3:0] ADDR_PREFIX = 4'b0101
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [2:0]        addr_strap,
   input  logic [TX_W-1:0]   tx_word,
   output logic              sda_oe,
   output logic [CMD_W-1:0]  cmd_byte,
   output logic              cmd_accept,
   output logic              conv_start
);

   link_state_t        state;
   logic [3:0]         bit_cnt;
   logic [CMD_W-1:0]   rx_sh;
   logic [7:0]         tx_sh;
   logic [7:0]         tx_lo;
   logic               rw_q;
   logic               second_q;
   logic               cmd_pend;
   logic               addr_hit;

   assign addr_hit = (rx_sh[7:1] == {ADDR_PREFIX, addr_strap});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= LNK_IDLE;
         bit_cnt    <= '0;
         rx_sh      <= '0;
         tx_sh      <= '0;
         tx_lo      <= '0;
         rw_q       <= 1'b0;
         second_q   <= 1'b0;
         cmd_pend   <= 1'b0;
         sda_oe     <= 1'b0;
         cmd_byte   <= '0;
         cmd_accept <= 1'b0;
         conv_start <= 1'b0;
      end else begin
         cmd_accept <= 1'b0;
         conv_start <= 1'b0;
         if (stop_det) begin
            state      <= LNK_IDLE;
            sda_oe     <= 1'b0;
            conv_start <= cmd_pend;
            cmd_pend   <= 1'b0;
         end else if (start_det) begin
            state   <= LNK_ADDR;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
         end else if (scl_rise) begin
            case (state)
               LNK_ADDR, LNK_CMD: begin
                  rx_sh   <= {rx_sh[CMD_W-2:0], sda_s};
                  bit_cnt <= bit_cnt + 4'd1;
               end
               LNK_RD_BYTE: bit_cnt <= bit_cnt + 4'd1;
               default: ;
            endcase
         end else if (scl_fall) begin
            case (state)
               LNK_ADDR: begin
                  if (bit_cnt == 4'd8) begin
                     if (addr_hit) begin
                        state  <= LNK_ADDR_ACK;
                        sda_oe <= 1'b1;
                        rw_q   <= rx_sh[0];
                     end else begin
                        state  <= LNK_IGNORE;
                     end
                  end
               end
               LNK_ADDR_ACK: begin
                  bit_cnt <= '0;
                  if (rw_q) begin
                     state    <= LNK_RD_BYTE;
                     second_q <= 1'b0;
                     tx_sh    <= tx_word[15:8];
                     tx_lo    <= tx_word[7:0];
                     sda_oe   <= ~tx_word[15];
                  end else begin
                     state    <= LNK_CMD;
                     sda_oe   <= 1'b0;
                  end
               end
               LNK_CMD: begin
                  if (bit_cnt == 4'd8) begin
                     if (rx_sh[7]) begin
                        state      <= LNK_CMD_ACK;
                        sda_oe     <= 1'b1;
                        cmd_byte   <= rx_sh;
                        cmd_accept <= 1'b1;
                        cmd_pend   <= 1'b1;
                     end else begin
                        state      <= LNK_IGNORE;
                     end
                  end
               end
               LNK_CMD_ACK: begin
                  state  <= LNK_IGNORE;
                  sda_oe <= 1'b0;
               end
               LNK_RD_BYTE: begin
                  if (bit_cnt == 4'd8) begin
                     state  <= LNK_RD_ACK;
                     sda_oe <= 1'b0;
                  end else if (bit_cnt != 4'd0) begin
                     tx_sh  <= {tx_sh[6:0], 1'b0};
                     sda_oe <= ~tx_sh[6];
                  end
               end
               LNK_RD_ACK: begin
                  if (!second_q) begin
                     state    <= LNK_RD_BYTE;
                     second_q <= 1'b1;
                     bit_cnt  <= '0;
                     tx_sh    <= tx_lo;
                     sda_oe   <= ~tx_lo[7];
                  end else begin
                     state    <= LNK_IGNORE;
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/adc_cmd_decode.sv
module adc_cmd_decode
   import adc_i2c_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic [CMD_W-2:0]    cmd_fields,
   input  logic                cmd_accept,
   output logic [CH_SEL_W-1:0] cfg_chan,
   output logic [NUM_CH-1:0]   cfg_chan_onehot,
   output logic                cfg_range,
   output logic                cfg_bipolar,
   output logic [1:0]          cfg_pwr,
   output logic                cfg_strobe
);

   pwr_mode_t pwr_next;

   always_comb begin
      if (!cmd_fields[1])     pwr_next = PWR_ON;
      else if (cmd_fields[0]) pwr_next = PWR_FULL;
      else                    pwr_next = PWR_STBY;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_chan    <= '0;
         cfg_range   <= 1'b0;
         cfg_bipolar <= 1'b0;
         cfg_pwr     <= PWR_ON;
         cfg_strobe  <= 1'b0;
      end else begin
         cfg_strobe <= cmd_accept;
         if (cmd_accept) begin
            cfg_chan    <= cmd_fields[6:4];
            cfg_range   <= cmd_fields[3];
            cfg_bipolar <= cmd_fields[2];
            cfg_pwr     <= pwr_next;
         end
      end
   end

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_hot
         assign cfg_chan_onehot[ch] = (cfg_chan == CH_SEL_W'(ch));
      end
   endgenerate

endmodule

// File: rtl/adc_cmd_i2c_slave.sv
module adc_cmd_i2c_slave
   import adc_i2c_pkg::*;
#(
   parameter int         RES_W       = 12,
   parameter int         SYNC_STAGES = 2,
   parameter logic [3:0] ADDR_PREFIX = 4'b0101
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 scl_i,
   input  logic                 sda_i,
   output logic                 sda_oe,
   input  logic [2:0]           addr_strap,
   input  logic [RES_W-1:0]     result_i,
   input  logic                 result_load,
   output logic [CH_SEL_W-1:0]  cfg_chan,
   output logic [NUM_CH-1:0]    cfg_chan_onehot,
   output logic                 cfg_range,
   output logic                 cfg_bipolar,
   output logic [1:0]           cfg_pwr,
   output logic                 cfg_strobe,
   output logic                 conv_start
);

   localparam int PAD_W = TX_W - RES_W;

   generate
      if (RES_W < 9 || RES_W > TX_W) begin : g_bad_res
         $error("RES_W must lie between 9 and 16");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic               scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic [RES_W-1:0]   res_q;
   logic [TX_W-1:0]    tx_word;
   logic [CMD_W-1:0]   cmd_byte;
   logic               cmd_accept;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           res_q <= '0;
      else if (result_load) res_q <= result_i;
   end

   generate
      if (PAD_W == 0) begin : g_full
         assign tx_word = res_q;
      end else begin : g_pad
         assign tx_word = {res_q, {PAD_W{1'b0}}};
      end
   endgenerate

   i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2c_link_fsm #(.ADDR_PREFIX(ADDR_PREFIX)) u_link (
      .clk        (clk),
      .rst_n      (rst_n),
      .sda_s      (sda_s),
      .scl_rise   (scl_rise),
      .scl_fall   (scl_fall),
      .start_det  (start_det),
      .stop_det   (stop_det),
      .addr_strap (addr_strap),
      .tx_word    (tx_word),
      .sda_oe     (sda_oe),
      .cmd_byte   (cmd_byte),
      .cmd_accept (cmd_accept),
      .conv_start (conv_start)
   );

   adc_cmd_decode u_dec (
      .clk             (clk),
      .rst_n           (rst_n),
      .cmd_fields      (cmd_byte[CMD_W-2:0]),
      .cmd_accept      (cmd_accept),
      .cfg_chan        (cfg_chan),
      .cfg_chan_onehot (cfg_chan_onehot),
      .cfg_range       (cfg_range),
      .cfg_bipolar     (cfg_bipolar),
      .cfg_pwr         (cfg_pwr),
      .cfg_strobe      (cfg_strobe)
   );

endmodule

// File: rtl/adc_i2c_slave_checker.sv
module adc_i2c_slave_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       scl_s,
   input logic       sda_oe,
   input logic [2:0] cfg_chan,
   input logic [7:0] cfg_chan_onehot,
   input logic       cfg_range,
   input logic       cfg_bipolar,
   input logic [1:0] cfg_pwr,
   input logic       cfg_strobe,
   input logic       conv_start
);

   p_sda_moves_scl_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> !$past(scl_s));

   p_cfg_only_on_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({cfg_chan, cfg_range, cfg_bipolar, cfg_pwr}) |-> cfg_strobe);

   p_pwr_code_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_pwr != 2'b01);

   p_onehot_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(cfg_chan_onehot) == 1);

   p_start_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);

   p_start_bus_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> !sda_oe);

endmodule

bind adc_cmd_i2c_slave adc_i2c_slave_checker u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .scl_s           (scl_s),
   .sda_oe          (sda_oe),
   .cfg_chan        (cfg_chan),
   .cfg_chan_onehot (cfg_chan_onehot),
   .cfg_range       (cfg_range),
   .cfg_bipolar     (cfg_bipolar),
   .cfg_pwr         (cfg_pwr),
   .cfg_strobe      (cfg_strobe),
   .conv_start      (conv_start)
);

// File: tb/sim_adc_cmd_i2c_slave.sv
`timescale 1ns/1ps
module sim_adc_cmd_i2c_slave;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        m_scl = 1'b1;
   logic        m_sda = 1'b1;
   logic        sda_oe;
   logic [2:0]  addr_strap = 3'b101;
   logic [11:0] result_i = '0;
   logic        result_load = 1'b0;
   logic [2:0]  cfg_chan;
   logic [7:0]  cfg_chan_onehot;
   logic        cfg_range, cfg_bipolar, cfg_strobe, conv_start;
   logic [1:0]  cfg_pwr;
   wire         sda_bus = m_sda & ~sda_oe;

   int n_chk = 0;
   int n_err = 0;
   int n_conv = 0;

   always #2.5 clk = ~clk;

   adc_cmd_i2c_slave u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
      .addr_strap(addr_strap), .result_i(result_i), .result_load(result_load),
      .cfg_chan(cfg_chan), .cfg_chan_onehot(cfg_chan_onehot), .cfg_range(cfg_range),
      .cfg_bipolar(cfg_bipolar), .cfg_pwr(cfg_pwr), .cfg_strobe(cfg_strobe),
      .conv_start(conv_start)
   );

   always @(posedge clk) if (conv_start) n_conv++;

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic bus_start;
      m_sda = 1'b1; wt(10);
      m_scl = 1'b1; wt(10);
      m_sda = 1'b0; wt(10);
      m_scl = 1'b0; wt(10);
   endtask

   task automatic bus_stop;
      m_sda = 1'b0; wt(10);
      m_scl = 1'b1; wt(10);
      m_sda = 1'b1; wt(30);
   endtask

   task automatic put_bit(input logic b);
      m_sda = b; wt(10);
      m_scl = 1'b1; wt(20);
      m_scl = 1'b0; wt(10);
   endtask

   task automatic get_bit(output logic b);
      m_sda = 1'b1; wt(10);
      m_scl = 1'b1; wt(10);
      b = sda_bus; wt(10);
      m_scl = 1'b0; wt(10);
   endtask

   task automatic put_byte(input logic [7:0] v, output logic acked);
      logic b;
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      get_bit(b);
      acked = ~b;
   endtask

   task automatic get_byte(output logic [7:0] v, input logic m_ack);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         v[i] = b;
      end
      put_bit(~m_ack);
   endtask

   task automatic write_cmd(input logic [7:0] adr, input logic [7:0] cmd,
                            output logic a1, output logic a2);
      bus_start;
      put_byte(adr, a1);
      put_byte(cmd, a2);
      bus_stop;
   endtask

   task automatic t_reset;
      chk("R1 sda_oe", sda_oe, 0);
      chk("R1 cfg_chan", cfg_chan, 0);
      chk("R1 onehot", cfg_chan_onehot, 8'h01);
      chk("R1 range/bip/pwr", {cfg_range, cfg_bipolar, cfg_pwr}, 0);
      chk("R1 conv_start", conv_start, 0);
   endtask

   task automatic t_write_main;
      logic a1, a2;
      write_cmd(8'h5A, 8'hEB, a1, a2);
      wt(5);
      chk("R2 addr ack", a1, 1);
      chk("R4 cmd ack", a2, 1);
      chk("R4 chan", cfg_chan, 6);
      chk("R4 onehot", cfg_chan_onehot, 8'h40);
      chk("R4 range/bip", {cfg_range, cfg_bipolar}, 2'b10);
      chk("R4 pwr full", cfg_pwr, 2'b11);
      chk("R8 conv after write", n_conv, 1);
   endtask

   task automatic t_pwr_normalise;
      logic a1, a2;
      write_cmd(8'h5A, 8'hB5, a1, a2);
      wt(5);
      chk("R4 ack", a2, 1);
      chk("R4 chan3", cfg_chan, 3);
      chk("R4 range/bip 01", {cfg_range, cfg_bipolar}, 2'b01);
      chk("R4 pwr pd1=0 -> 00", cfg_pwr, 2'b00);
      chk("R8 conv count", n_conv, 2);
   endtask

   task automatic t_mismatch;
      logic a1, a2;
      write_cmd(8'h50, 8'h8F, a1, a2);
      wt(5);
      chk("R3 no addr ack", a1, 0);
      chk("R3 no cmd ack", a2, 0);
      chk("R3 chan kept", cfg_chan, 3);
      chk("R3 pwr kept", cfg_pwr, 2'b00);
      chk("R8 no conv on mismatch", n_conv, 2);
   endtask

   task automatic t_lead_zero;
      logic a1, a2;
      write_cmd(8'h5A, 8'h7F, a1, a2);
      wt(5);
      chk("R5 addr ack", a1, 1);
      chk("R5 cmd nack", a2, 0);
      chk("R5 chan kept", cfg_chan, 3);
      chk("R5 flags kept", {cfg_range, cfg_bipolar, cfg_pwr}, 4'b0100);
      chk("R8 no conv on rejected cmd", n_conv, 2);
   endtask

   task automatic t_read_empty;
      logic a1;
      logic [7:0] hi, lo;
      bus_start;
      put_byte(8'h5B, a1);
      get_byte(hi, 1'b1);
      get_byte(lo, 1'b0);
      bus_stop;
      chk("R10 read ack", a1, 1);
      chk("R10 hi before load", hi, 8'h00);
      chk("R10 lo before load", lo, 8'h00);
   endtask

   task automatic t_read_loaded;
      logic a1;
      logic [7:0] hi, lo, extra;
      @(negedge clk); result_i = 12'hA5C; result_load = 1'b1;
      @(negedge clk); result_load = 1'b0; result_i = 12'h123;
      bus_start;
      put_byte(8'h5B, a1);
      get_byte(hi, 1'b1);
      get_byte(lo, 1'b1);
      get_byte(extra, 1'b0);
      bus_stop;
      chk("R6 hi byte", hi, 8'hA5);
      chk("R6 lo byte", lo, 8'hC0);
      chk("R7 third byte released", extra, 8'hFF);
      chk("R8 no conv on read", n_conv, 2);
   endtask

   task automatic t_read_nack;
      logic a1;
      logic [7:0] hi, lo;
      bus_start;
      put_byte(8'h5B, a1);
      get_byte(hi, 1'b0);
      get_byte(lo, 1'b0);
      bus_stop;
      chk("R7 hi with nack", hi, 8'hA5);
      chk("R7 lo after nack", lo, 8'hC0);
   endtask

   task automatic t_snapshot;
      logic a1;
      logic [7:0] hi, lo;
      bus_start;
      put_byte(8'h5B, a1);
      @(negedge clk); result_i = 12'h3E7; result_load = 1'b1;
      @(negedge clk); result_load = 1'b0;
      get_byte(hi, 1'b1);
      get_byte(lo, 1'b0);
      bus_stop;
      chk("R6 snapshot hi", hi, 8'hA5);
      chk("R6 snapshot lo", lo, 8'hC0);
   endtask

   task automatic t_restart;
      logic a1, a2;
      logic [7:0] hi, lo;
      bus_start;
      put_byte(8'h5A, a1);
      bus_start;
      put_byte(8'h5B, a2);
      get_byte(hi, 1'b1);
      get_byte(lo, 1'b0);
      bus_stop;
      chk("R9 read after restart ack", a2, 1);
      chk("R9 read after restart hi", hi, 8'h3E);
      chk("R9 read after restart lo", lo, 8'h70);
      bus_start;
      put_byte(8'h50, a1);
      bus_start;
      put_byte(8'h5A, a1);
      put_byte(8'h91, a2);
      bus_stop;
      wt(5);
      chk("R9 ack after restart", a1, 1);
      chk("R9 chan after restart", cfg_chan, 1);
      chk("R9 pwr after restart", cfg_pwr, 2'b00);
      chk("R8 conv after restart write", n_conv, 3);
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      summary;
      $finish;
   end

   initial begin
      wt(6);
      t_reset;
      rst_n = 1'b1;
      wt(6);
      t_reset;
      t_write_main;
      t_pwr_normalise;
      t_mismatch;
      t_lead_zero;
      t_read_empty;
      t_read_loaded;
      t_read_nack;
      t_snapshot;
      t_restart;
      summary;
      $finish;
   end

endmodule